// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block sits on the host side of a parallel NOR flash. After software has launched an embedded program or erase, it decides when that operation has ended and whether it ended well. It reads the device's status byte through a simple bus master port and compares the toggle bit (bit 6) across two back-to-back reads. While that bit keeps flipping it reads again in pairs. When the time-limit flag (bit 5) is seen high it takes one more pair of reads, because the toggling may stop just as that flag rises.

If the device is still busy after that confirming pair, the operation has failed. The poller then writes a reset command byte to a fixed address, which returns the device to array reads. A pair counter bounds the wait and gives a timeout result if the status never settles. A host that gives up polling can raise abort. The next start always begins from a fresh pair of reads with a cleared counter.

The start request is a valid/ready handshake. `start_ready_o` is high only while the poller is idle, and a start offered while it is low is not taken. Each bus access is a request held high with a stable address until the bus side returns a one-cycle `ack_i`. The bus side may stall for any number of cycles, and read data is used only in the cycle of `ack_i`.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset the poller is idle: `start_ready_o`=1, `rd_req_o`=0, `wr_req_o`=0, `done_o`=0 and `result_o`=2'b00.
- R2: A start is taken when `start_valid_i` and `start_ready_o` are both high at a clock edge. In the next cycle a status read is requested at address STATUS_ADDR.
- R3: A read or write request stays high, with its address held, until the cycle in which `ack_i` is high. `rdata_i` is sampled only in that cycle, and its value in any other cycle has no effect.
- R4: If bit 6 is equal in the two reads of a pair, `done_o` pulses in the cycle after the second read's ack, with `result_o`=2'b01, and no write is issued.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 0, another pair of reads follows.
- R6: If bit 6 differs and bit 5 of the second read is 1, one more pair is read. If bit 6 is equal in that pair, the result is 2'b01.
- R7: If bit 6 still differs in the confirming pair, one write of RESET_CMD (default 8'hF0) to RESET_ADDR is requested. `done_o` pulses with `result_o`=2'b10 in the cycle after that write's ack.
- R8: When MAX_PAIRS consecutive pairs have toggled with bit 5 low, `done_o` pulses with `result_o`=2'b11 and no write is issued.
- R9: `done_o` lasts one cycle. `result_o` is 2'b00 whenever `done_o` is low.
- R10: An `abort_i` pulse during polling returns the poller to idle at the next acknowledged read, with no `done_o`. The next start begins a new first pair with the pair count cleared.
- R11: A start offered while the poller is busy is ignored and produces no extra reads or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Request to begin polling |
| start_ready_o | output | 1 | Poller idle and able to take a start |
| abort_i | input | 1 | Host abandons polling |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 01 ok, 10 device failure, 11 timeout |
| rd_req_o | output | 1 | Bus read request, held until ack |
| wr_req_o | output | 1 | Bus write request, held until ack |
| addr_o | output | ADDR_W | Bus address |
| wdata_o | output | DATA_W | Bus write data |
| rdata_i | input | DATA_W | Bus read data, valid with ack |
| ack_i | input | 1 | Bus transfer complete |

## Verification
A captured first byte that is wrong, or sampled off the ack cycle, shows up as the wrong result code. That code appears on the `done_o` pulse one cycle after the second read of the pair that decides it. A wrong decision about the next state shows up as a different number of bus reads, or as a missing or extra reset write, which is visible as soon as the transfer is requested. A pair counter that is not cleared only shows up later, as a timeout several pairs early after a restart. The bench therefore counts reads and writes per scenario and times the done pulse against the last ack.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_A, ST_RD_B, ST_CF_A, ST_CF_B, ST_RST_WR, ST_DONE
  } ftp_state_t;

  localparam logic [1:0] RES_NONE = 2'b00;
  localparam logic [1:0] RES_OK   = 2'b01;
  localparam logic [1:0] RES_FAIL = 2'b10;
  localparam logic [1:0] RES_TMO  = 2'b11;

  localparam int TOG_POS = 6;
  localparam int LIM_POS = 5;
endpackage

// File: rtl/ftp_toggle_cmp.sv
module ftp_toggle_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic tog_i,
  input  logic lim_i,
  output logic toggled_o,
  output logic limit_o
);
  logic first_tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     first_tog_q <= 1'b0;
    else if (cap_i) first_tog_q <= tog_i;
  end

  assign toggled_o = first_tog_q ^ tog_i;
  assign limit_o   = lim_i;

  // R3: the held first sample changes only on a capture strobe
  p_hold_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(first_tog_q));
endmodule

// File: rtl/ftp_pair_ctr.sv
module ftp_pair_ctr #(
  parameter int MAX_PAIRS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_PAIRS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // R8: the count never passes the last permitted pair
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int          ADDR_W      = 22,
  parameter int          DATA_W      = 8,
  parameter int          MAX_PAIRS   = 4096,
  parameter logic [21:0] STATUS_ADDR = 22'h000000,
  parameter logic [21:0] RESET_ADDR  = 22'h000000,
  parameter logic [7:0]  RESET_CMD   = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic              abort_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ack_i
);
  ftp_state_t state_q, state_d;
  logic [1:0] res_q, res_d;
  logic       abort_pend_q;
  logic       rd_ack, wr_ack, cap, toggled, limit;
  logic       ctr_clr, ctr_inc, ctr_last;
  logic       unused_rdata;

  assign unused_rdata = ^rdata_i;

  assign rd_req_o = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                    (state_q == ST_CF_A) || (state_q == ST_CF_B);
  assign wr_req_o = (state_q == ST_RST_WR);
  assign addr_o   = wr_req_o ? ADDR_W'(RESET_ADDR) : ADDR_W'(STATUS_ADDR);
  assign wdata_o  = DATA_W'(RESET_CMD);
  assign rd_ack   = rd_req_o && ack_i;
  assign wr_ack   = wr_req_o && ack_i;
  assign cap      = rd_ack && !abort_pend_q &&
                    ((state_q == ST_RD_A) || (state_q == ST_CF_A));

  assign start_ready_o = (state_q == ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign result_o      = done_o ? res_q : RES_NONE;

  ftp_toggle_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .cap_i(cap),
    .tog_i(rdata_i[TOG_POS]), .lim_i(rdata_i[LIM_POS]),
    .toggled_o(toggled), .limit_o(limit)
  );

  ftp_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(ctr_clr), .inc_i(ctr_inc),
    .last_o(ctr_last)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    case (state_q)
      ST_IDLE: if (start_valid_i) begin
        state_d = ST_RD_A;
        ctr_clr = 1'b1;
      end
      ST_RD_A, ST_CF_A: if (rd_ack) begin
        if (abort_pend_q)             state_d = ST_IDLE;
        else if (state_q == ST_RD_A)  state_d = ST_RD_B;
        else                          state_d = ST_CF_B;
      end
      ST_RD_B: if (rd_ack) begin
        if (abort_pend_q) state_d = ST_IDLE;
        else if (!toggled) begin
          state_d = ST_DONE; res_d = RES_OK;
        end else if (limit) state_d = ST_CF_A;
        else if (ctr_last) begin
          state_d = ST_DONE; res_d = RES_TMO;
        end else begin
          state_d = ST_RD_A; ctr_inc = 1'b1;
        end
      end
      ST_CF_B: if (rd_ack) begin
        if (abort_pend_q) state_d = ST_IDLE;
        else if (!toggled) begin
          state_d = ST_DONE; res_d = RES_OK;
        end else state_d = ST_RST_WR;
      end
      ST_RST_WR: if (wr_ack) begin
        state_d = ST_DONE; res_d = RES_FAIL;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      res_q        <= RES_NONE;
      abort_pend_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      res_q        <= res_d;
      abort_pend_q <= (state_q == ST_IDLE) ? 1'b0 : (abort_pend_q || abort_i);
    end
  end

  // R1: an idle poller has no bus activity
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready_o |-> !rd_req_o && !wr_req_o && !done_o);
  // R2: an accepted start leads straight to a read
  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_i && start_ready_o |=> rd_req_o);
  // R3: a stalled read keeps its request and address
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !ack_i |=> rd_req_o && $stable(addr_o));
  // R7: a stalled reset write keeps its request
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !ack_i |=> wr_req_o && $stable(addr_o));
  // R7: a failure report follows an acknowledged reset write
  p_fail_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (result_o == RES_FAIL) |-> $past(wr_req_o && ack_i));
  // R9: completion is a single-cycle pulse with a coded result
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> result_o != RES_NONE);
  // R4: read and write requests never overlap
  p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, wr_req_o, done_o}));
endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  localparam int          AW    = 22;
  localparam int          DW    = 8;
  localparam int          MAXP  = 4;
  localparam logic [21:0] ST_A  = 22'h00AAA;
  localparam logic [21:0] RS_A  = 22'h00555;
  localparam logic [7:0]  CMD   = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid_i = 1'b0, abort_i = 1'b0, ack_i = 1'b0;
  logic [DW-1:0] rdata_i = '0;
  logic start_ready_o, done_o, rd_req_o, wr_req_o;
  logic [1:0] result_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o;

  always #2 clk = ~clk;

  flash_toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(MAXP),
    .STATUS_ADDR(ST_A), .RESET_ADDR(RS_A), .RESET_CMD(CMD)) i_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_valid_i(start_valid_i),
    .start_ready_o(start_ready_o), .abort_i(abort_i), .done_o(done_o),
    .result_o(result_o), .rd_req_o(rd_req_o), .wr_req_o(wr_req_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .rdata_i(rdata_i), .ack_i(ack_i));

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] script [64];
  int wp = 0, rp = 0, lat = 0, wcnt = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, bad_addr = 0, leak = 0;
  int ack_cyc = 0, done_cyc = 0;
  logic [1:0] last_res = 2'b00;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus responder and output monitor, all at the falling edge
  initial forever begin
    @(negedge clk);
    if (done_o) begin done_cnt++; last_res = result_o; done_cyc = cyc; end
    else if (result_o != 2'b00) leak++;
    ack_i = 1'b0;
    rdata_i = cyc[0] ? 8'h60 : 8'h20;   // junk off the ack cycle (R3)
    if (rd_req_o || wr_req_o) begin
      if (wcnt >= lat) begin
        ack_i = 1'b1; wcnt = 0; ack_cyc = cyc;
        if (rd_req_o) begin
          rd_cnt++;
          if (addr_o != ST_A) bad_addr++;
          rdata_i = (rp < wp) ? script[rp] : 8'h40;
          rp++;
        end else begin
          wr_cnt++; wr_addr = addr_o; wr_data = wdata_o;
        end
      end else wcnt++;
    end
  end

  task automatic clear_case(input int l);
    wp = 0; rp = 0; lat = l; rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    bad_addr = 0; leak = 0;
  endtask

  task automatic push(input logic [7:0] b);
    script[wp] = b; wp++;
  endtask

  task automatic start_one();
    @(negedge clk); start_valid_i = 1'b1;
    @(negedge clk); start_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(start_ready_o == 1'b1, "R1", "ready", start_ready_o, 1);
    chk(!rd_req_o && !wr_req_o, "R1", "requests", {rd_req_o, wr_req_o}, 0);
    chk(!done_o && result_o == 2'b00, "R1", "done/result", {done_o, result_o}, 0);
  endtask

  task automatic t_settle_now();
    clear_case(3); push(8'h40); push(8'h40);
    start_one(); wait_done();
    chk(last_res == 2'b01, "R4", "result", last_res, 1);
    chk(done_cyc == ack_cyc + 1, "R4", "done latency", done_cyc - ack_cyc, 1);
    chk(rd_cnt == 2 && wr_cnt == 0, "R4", "reads/writes", rd_cnt * 16 + wr_cnt, 32);
    chk(bad_addr == 0, "R2", "read address", bad_addr, 0);
    chk(done_cnt == 1 && leak == 0, "R9", "pulse/leak", done_cnt * 16 + leak, 16);
  endtask

  task automatic t_toggle_then_settle();
    clear_case(1); push(8'h00); push(8'h40); push(8'h40); push(8'h40);
    start_one();
    repeat (3) @(negedge clk);
    start_one();                      // R11 start while busy
    wait_done();
    chk(last_res == 2'b01, "R5", "result", last_res, 1);
    chk(rd_cnt == 4, "R5", "reads", rd_cnt, 4);
    chk(done_cnt == 1, "R11", "done count", done_cnt, 1);
    chk(bad_addr == 0, "R3", "junk ignored / address", bad_addr, 0);
  endtask

  task automatic t_limit_stops();
    clear_case(0); push(8'h00); push(8'h60); push(8'h60); push(8'h60);
    start_one(); wait_done();
    chk(last_res == 2'b01, "R6", "result", last_res, 1);
    chk(rd_cnt == 4 && wr_cnt == 0, "R6", "reads/writes", rd_cnt * 16 + wr_cnt, 64);
  endtask

  task automatic t_limit_fails();
    clear_case(2); push(8'h00); push(8'h60); push(8'h20); push(8'h60);
    start_one(); wait_done();
    chk(last_res == 2'b10, "R7", "result", last_res, 2);
    chk(wr_cnt == 1, "R7", "write count", wr_cnt, 1);
    chk(wr_addr == RS_A && wr_data == CMD, "R7", "write addr/data",
        {wr_addr, wr_data}, {RS_A, CMD});
    chk(done_cyc == ack_cyc + 1, "R7", "done after write ack", done_cyc - ack_cyc, 1);
    chk(rd_cnt == 4, "R7", "reads", rd_cnt, 4);
  endtask

  task automatic t_timeout();
    clear_case(1);
    for (int i = 0; i < 8; i++) push(i[0] ? 8'h40 : 8'h00);
    start_one(); wait_done();
    chk(last_res == 2'b11, "R8", "result", last_res, 3);
    chk(rd_cnt == 2 * MAXP && wr_cnt == 0, "R8", "reads/writes",
        rd_cnt * 16 + wr_cnt, 2 * MAXP * 16);
  endtask

  task automatic t_abort();
    clear_case(3);
    for (int i = 0; i < 5; i++) push(i[0] ? 8'h40 : 8'h00);
    start_one();
    for (int i = 0; i < 400 && rp < 4; i++) @(negedge clk);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(done_cnt == 0, "R10", "no done on abort", done_cnt, 0);
    chk(start_ready_o == 1'b1 && rd_cnt == 5, "R10", "idle after abort",
        {start_ready_o, 8'(rd_cnt)}, {1'b1, 8'd5});
    clear_case(1);
    for (int i = 0; i < 6; i++) push(i[0] ? 8'h40 : 8'h00);
    push(8'h40); push(8'h40);
    start_one(); wait_done();
    chk(last_res == 2'b01, "R10", "fresh count after restart", last_res, 1);
    chk(rd_cnt == 8, "R10", "reads after restart", rd_cnt, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_settle_now();
    t_toggle_then_settle();
    t_limit_stops();
    t_limit_fails();
    t_timeout();
    t_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule